// File: doc/BRIEF.md
# Sequenced 4x4 Matrix-Vector Multiplier

This block applies a 4x4 matrix of unsigned fixed-point coefficients to a four-element coordinate. One multiply-add unit does all sixteen multiply-accumulate steps in turn, and a control state machine sequences it. A single 9-bit input bus carries both kinds of data: the sixteen 9-bit coefficients when a load is requested, and the four 8-bit coordinate values when a transform is started. The coefficients are kept in a small on-chip RAM. On a dump request they are read back, one per cycle, onto a separate coefficient output bus.

A coefficient is an unsigned value in which 0x100 stands for 1.0. A coordinate is an unsigned 0.8 fraction, so 0xFF is as close to one as it can get. Each of the four results is the saturated sum of four products. The results leave the block on four consecutive cycles, in coordinate order. A registered busy flag and a registered output-ready flag tell the surrounding logic when the block is occupied and when an output bus holds valid data.

Top module: `mat_xform`

## Requirements
- R1: While reset (rstN low, asynchronous) is asserted and after it is released, busy and outRdy are 0 and both dataOut and coefOut are 0.
- R2: A load starts on the clock edge where loadReq is sampled high in idle, with coefficient index 0 on dataIn. Indices 1 to 15 follow on the next 15 edges. Index 4*row+col is the row-major position. busy is high after the starting edge and after each of the next 14 edges, and low after the 15th.
- R3: A dump started at edge 0 puts coefficient k on coefOut after edge k+2, for k = 0 to 15, with outRdy high on those 16 consecutive cycles and low after edges 1 and 18. busy is low after edge 16.
- R4: A transform starts on the edge where startReq is sampled high in idle. X is taken from dataIn[7:0] on that edge, and Y, Z and W on the following three edges.
- R5: Each product is floor(coef*coord/256). Row r gives the sum of its four products, clamped to 255 at every addition, never wrapped.
- R6: With 0x100 on the diagonal and 0 elsewhere, the four results equal X, Y, Z and W exactly.
- R7: With start sampled at edge 0, X', Y', Z' and W' appear on dataOut after edges 20, 21, 22 and 23 in that order, with outRdy high on those cycles. outRdy is low after edge 19.
- R8: busy is high from the cycle after start up to and including the cycle after edge 22, and low after edge 23, so one transform takes 24 cycles (within a budget of 50).
- R9: loadReq, dumpReq and startReq sampled while busy is high have no effect: the results of the running transform and the stored coefficients stay unchanged.
- R10: When several requests are sampled together in idle, load wins over dump and dump wins over start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 9 | Shared bus for coefficients (9 bits) and coordinates (low 8 bits) |
| loadReq | input | 1 | Begin storing 16 coefficients, first one on this cycle |
| dumpReq | input | 1 | Begin reading the 16 coefficients back onto coefOut |
| startReq | input | 1 | Begin a transform, X on dataIn this cycle |
| coefOut | output | 9 | Coefficient read back during a dump |
| dataOut | output | 8 | Transformed coordinate element |
| busy | output | 1 | Registered: a load, dump or transform is in progress |
| outRdy | output | 1 | Registered: coefOut or dataOut holds valid data this cycle |

## Verification
The properties assume that any request seen while the block is idle comes with its first data word on dataIn in the same cycle. They also assume that the remaining words of a load or transform follow on the next cycles with no gaps. The bench changes every input on the falling clock edge, so each word is stable around the rising edge that captures it. The bench raises a request for exactly one cycle, except where it deliberately sends requests into a busy window to check that they are ignored. Those stray requests are always withdrawn well before busy falls, so none of them can start a new operation.

// File: rtl/mx_pkg.sv
package mx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DUMP,
    ST_CAPT,
    ST_MAC,
    ST_SHOW
  } mxState_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic wrEn;    // write dataIn into coefficient RAM
    logic capEn;   // capture one coordinate element
    logic macGo;   // one multiply-accumulate step is being read out of the RAM
    logic dumpGo;  // one coefficient is being read for the dump stream
    logic showGo;  // present one stored result
  } mxCtl_t;

endpackage

// File: rtl/mx_coef_ram.sv
module mx_coef_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] mem [DEPTH];

  // single address, registered read
  always_ff @(posedge clk) begin
    if (wrEn) mem[addr] <= wrData;
    rdData <= mem[addr];
  end

endmodule

// File: rtl/mx_muladd.sv
module mx_muladd #(
  parameter int COEF_W = 9,
  parameter int CRD_W  = 8
) (
  input  logic [COEF_W-1:0] coef,
  input  logic [CRD_W-1:0]  coord,
  input  logic [CRD_W-1:0]  accIn,
  output logic [CRD_W-1:0]  sum
);

  localparam int PW = COEF_W + CRD_W;
  localparam logic [COEF_W:0] SAT_V = (COEF_W+1)'((1 << CRD_W) - 1);

  logic [PW-1:0]     prodFull;
  logic [COEF_W-1:0] prod;
  logic [COEF_W:0]   wide;

  assign prodFull = {{CRD_W{1'b0}}, coef} * {{COEF_W{1'b0}}, coord};
  assign prod     = prodFull[PW-1:CRD_W];
  assign wide     = {1'b0, prod} + (COEF_W+1)'(accIn);
  assign sum      = (wide > SAT_V) ? SAT_V[CRD_W-1:0] : wide[CRD_W-1:0];

endmodule

// File: rtl/mx_ctrl.sv
module mx_ctrl
  import mx_pkg::*;
#(
  parameter int DIM = 4,
  localparam int N  = DIM * DIM,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadReq,
  input  logic          dumpReq,
  input  logic          startReq,
  output mxCtl_t        ctl,
  output logic [AW-1:0] idx,
  output logic          busy
);

  localparam logic [AW-1:0] LAST_N = AW'(N - 1);
  localparam logic [AW-1:0] LAST_D = AW'(DIM - 1);

  mxState_e state;
  logic [AW-1:0] cnt;

  assign idx = cnt;

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_IDLE: begin
        if (loadReq)                  ctl.wrEn  = 1'b1;
        else if (!dumpReq && startReq) ctl.capEn = 1'b1;
      end
      ST_LOAD: ctl.wrEn   = 1'b1;
      ST_DUMP: ctl.dumpGo = 1'b1;
      ST_CAPT: ctl.capEn  = 1'b1;
      ST_MAC:  ctl.macGo  = 1'b1;
      ST_SHOW: ctl.showGo = 1'b1;
      default: ctl = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      busy  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (loadReq) begin
            state <= ST_LOAD;
            cnt   <= AW'(1);
            busy  <= 1'b1;
          end else if (dumpReq) begin
            state <= ST_DUMP;
            cnt   <= '0;
            busy  <= 1'b1;
          end else if (startReq) begin
            state <= ST_CAPT;
            cnt   <= AW'(1);
            busy  <= 1'b1;
          end
        end
        ST_LOAD, ST_DUMP: begin
          if (cnt == LAST_N) begin
            state <= ST_IDLE;
            cnt   <= '0;
            busy  <= 1'b0;
          end else begin
            cnt <= cnt + AW'(1);
          end
        end
        ST_CAPT: begin
          if (cnt == LAST_D) begin
            state <= ST_MAC;
            cnt   <= '0;
          end else begin
            cnt <= cnt + AW'(1);
          end
        end
        ST_MAC: begin
          if (cnt == LAST_N) begin
            state <= ST_SHOW;
            cnt   <= '0;
          end else begin
            cnt <= cnt + AW'(1);
          end
        end
        ST_SHOW: begin
          if (cnt == LAST_D) begin
            state <= ST_IDLE;
            cnt   <= '0;
            busy  <= 1'b0;
          end else begin
            cnt <= cnt + AW'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
          busy  <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/mx_datapath.sv
module mx_datapath
  import mx_pkg::*;
#(
  parameter int DIM    = 4,
  parameter int COEF_W = 9,
  parameter int CRD_W  = 8,
  localparam int IW    = $clog2(DIM),
  localparam int AW    = 2 * IW
) (
  input  logic              clk,
  input  logic              rstN,
  input  mxCtl_t            ctl,
  input  logic [AW-1:0]     idx,
  input  logic [CRD_W-1:0]  crdIn,
  input  logic [COEF_W-1:0] ramQ,
  output logic [COEF_W-1:0] coefOut,
  output logic [CRD_W-1:0]  dataOut,
  output logic              outRdy
);

  logic [CRD_W-1:0] crd [DIM];
  logic [CRD_W-1:0] res [DIM];
  logic [CRD_W-1:0] acc;
  logic             macVld;
  logic             dumpVld;
  logic [AW-1:0]    macTag;
  logic [IW-1:0]    col;
  logic [IW-1:0]    row;
  logic [CRD_W-1:0] accIn;
  logic [CRD_W-1:0] sum;

  assign col   = macTag[IW-1:0];
  assign row   = macTag[AW-1:IW];
  // first column of a row starts from zero instead of clearing acc
  assign accIn = (col == '0) ? '0 : acc;

  mx_muladd #(.COEF_W(COEF_W), .CRD_W(CRD_W)) uMulAdd (
    .coef  (ramQ),
    .coord (crd[col]),
    .accIn (accIn),
    .sum   (sum)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DIM; i++) begin
        crd[i] <= '0;
        res[i] <= '0;
      end
      acc     <= '0;
      macVld  <= 1'b0;
      macTag  <= '0;
      dumpVld <= 1'b0;
      coefOut <= '0;
      dataOut <= '0;
      outRdy  <= 1'b0;
    end else begin
      macVld  <= ctl.macGo;
      macTag  <= idx;
      dumpVld <= ctl.dumpGo;
      outRdy  <= ctl.showGo | dumpVld;
      if (ctl.capEn) crd[idx[IW-1:0]] <= crdIn;
      if (macVld) begin
        acc <= sum;
        if (col == IW'(DIM - 1)) res[row] <= sum;
      end
      if (dumpVld)    coefOut <= ramQ;
      if (ctl.showGo) dataOut <= res[idx[IW-1:0]];
    end
  end

endmodule

// File: rtl/mat_xform.sv
module mat_xform
  import mx_pkg::*;
#(
  parameter int DIM    = 4,
  parameter int COEF_W = 9,
  parameter int CRD_W  = 8,
  localparam int N     = DIM * DIM,
  localparam int AW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [COEF_W-1:0] dataIn,
  input  logic              loadReq,
  input  logic              dumpReq,
  input  logic              startReq,
  output logic [COEF_W-1:0] coefOut,
  output logic [CRD_W-1:0]  dataOut,
  output logic              busy,
  output logic              outRdy
);

  mxCtl_t ctl;
  logic [AW-1:0] idx;
  logic [COEF_W-1:0] ramQ;

  mx_ctrl #(.DIM(DIM)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadReq  (loadReq),
    .dumpReq  (dumpReq),
    .startReq (startReq),
    .ctl      (ctl),
    .idx      (idx),
    .busy     (busy)
  );

  mx_coef_ram #(.DEPTH(N), .WIDTH(COEF_W)) uRam (
    .clk    (clk),
    .wrEn   (ctl.wrEn),
    .addr   (idx),
    .wrData (dataIn),
    .rdData (ramQ)
  );

  mx_datapath #(.DIM(DIM), .COEF_W(COEF_W), .CRD_W(CRD_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .idx     (idx),
    .crdIn   (dataIn[CRD_W-1:0]),
    .ramQ    (ramQ),
    .coefOut (coefOut),
    .dataOut (dataOut),
    .outRdy  (outRdy)
  );

endmodule

// File: rtl/mx_check.sv
module mx_check #(
  parameter int N      = 16,
  parameter int COEF_W = 9,
  parameter int CRD_W  = 8,
  parameter int BUDGET = 50
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadReq,
  input logic              dumpReq,
  input logic              startReq,
  input logic              busy,
  input logic              outRdy,
  input logic [COEF_W-1:0] coefOut,
  input logic [CRD_W-1:0]  dataOut
);

  logic [15:0] busyRun;
  logic [15:0] rdyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyRun <= '0;
      rdyRun  <= '0;
    end else begin
      busyRun <= busy   ? busyRun + 16'd1 : '0;
      rdyRun  <= outRdy ? rdyRun + 16'd1  : '0;
    end
  end

  // R8: any request seen in idle makes busy high on the next cycle
  a_r8_busy_after_request: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (loadReq || dumpReq || startReq)) |=> busy);

  // R8: no operation keeps the block busy past the cycle budget
  a_r8_within_budget: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= 16'(BUDGET));

  // R3: a run of valid output words never exceeds one full matrix
  a_r3_ready_run: assert property (@(posedge clk) disable iff (!rstN)
    rdyRun <= 16'(N));

  // R7: valid output only ever begins inside an operation
  a_r7_ready_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outRdy) |-> $past(busy));

  // R3: output buses do not move while nothing is marked valid
  a_r3_quiet_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !outRdy |-> ($stable(coefOut) && $stable(dataOut)));

endmodule

bind mat_xform mx_check #(.N(DIM*DIM), .COEF_W(COEF_W), .CRD_W(CRD_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .loadReq  (loadReq),
  .dumpReq  (dumpReq),
  .startReq (startReq),
  .busy     (busy),
  .outRdy   (outRdy),
  .coefOut  (coefOut),
  .dataOut  (dataOut)
);

// File: tb/sim_mat_xform.sv
module sim_mat_xform;

  logic       clk = 1'b0;
  logic       rstN;
  logic [8:0] dataIn;
  logic       loadReq, dumpReq, startReq;
  logic [8:0] coefOut;
  logic [7:0] dataOut;
  logic       busy, outRdy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [8:0] mat [16];
  logic [7:0] vec [4];

  always #4 clk = ~clk;

  mat_xform u0 (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .loadReq(loadReq),
    .dumpReq(dumpReq), .startReq(startReq), .coefOut(coefOut),
    .dataOut(dataOut), .busy(busy), .outRdy(outRdy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int refRow(input int r);
    int acc = 0;
    for (int c = 0; c < 4; c++) begin
      acc = acc + ((int'(mat[4*r+c]) * int'(vec[c])) >> 8);
      if (acc > 255) acc = 255;
    end
    return acc;
  endfunction

  task automatic t_reset();
    rstN = 1'b0; dataIn = '0; loadReq = 0; dumpReq = 0; startReq = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && outRdy == 0, "R1 flags in reset", int'({busy, outRdy}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && outRdy == 0, "R1 flags after reset", int'({busy, outRdy}), 0);
    chk(dataOut == 0 && coefOut == 0, "R1 buses after reset", int'(dataOut) + int'(coefOut), 0);
  endtask

  task automatic t_load(input bit others, input string tag);
    for (int k = 0; k < 16; k++) begin
      dataIn   = mat[k];
      loadReq  = (k == 0);
      dumpReq  = others && (k == 0);
      startReq = others && (k == 0);
      @(negedge clk);
      chk(busy == (k < 15), tag, int'(busy), int'(k < 15));
    end
    loadReq = 0; dumpReq = 0; startReq = 0;
  endtask

  task automatic t_dump(input bit withStart, input string tag);
    dumpReq = 1; startReq = withStart; dataIn = 9'h0AA;
    for (int e = 0; e <= 18; e++) begin
      @(negedge clk);
      if (e == 0) begin dumpReq = 0; startReq = 0; end
      if (e >= 2 && e <= 17) begin
        chk(outRdy == 1, tag, int'(outRdy), 1);
        chk(coefOut == mat[e-2], tag, int'(coefOut), int'(mat[e-2]));
      end else begin
        chk(outRdy == 0, tag, int'(outRdy), 0);
      end
      if (e == 0)  chk(busy == 1, "R3 busy during dump", int'(busy), 1);
      if (e == 16) chk(busy == 0, "R3 busy after dump", int'(busy), 0);
    end
  endtask

  task automatic t_xform(input bit noise, input string tag);
    int expv [4];
    for (int r = 0; r < 4; r++) expv[r] = refRow(r);
    startReq = 1; dataIn = {1'b0, vec[0]};
    for (int e = 0; e <= 23; e++) begin
      @(negedge clk);
      if (e == 0) startReq = 0;
      if (e < 3) dataIn = {1'b0, vec[e+1]};
      else dataIn = 9'h155;
      if (noise) begin
        loadReq  = (e >= 5 && e <= 7);
        dumpReq  = (e >= 5 && e <= 7);
        startReq = (e >= 5 && e <= 7);
      end
      if (e == 0)  chk(busy == 1, "R8 busy after start", int'(busy), 1);
      if (e == 22) chk(busy == 1, "R8 busy before last result", int'(busy), 1);
      if (e == 23) chk(busy == 0, "R8 busy after last result", int'(busy), 0);
      if (e == 19) chk(outRdy == 0, "R7 no result yet", int'(outRdy), 0);
      if (e >= 20) begin
        chk(outRdy == 1, "R7 result ready", int'(outRdy), 1);
        chk(int'(dataOut) == expv[e-20], tag, int'(dataOut), expv[e-20]);
      end
    end
  endtask

  initial begin
    t_reset();

    // identity matrix, load then read back
    for (int k = 0; k < 16; k++) mat[k] = (k % 5 == 0) ? 9'h100 : 9'h000;
    t_load(1'b0, "R2 busy during load");
    t_dump(1'b0, "R2/R3 dump of identity");
    vec[0] = 8'd12; vec[1] = 8'd34; vec[2] = 8'd56; vec[3] = 8'd200;
    t_xform(1'b0, "R6 identity passes coordinate");

    // graded matrix, coordinates all near one, then distinct values
    for (int k = 0; k < 16; k++) mat[k] = 9'(k * 13 + 3);
    t_load(1'b0, "R2 busy during load");
    for (int c = 0; c < 4; c++) vec[c] = 8'hFF;
    t_xform(1'b0, "R5 full-scale coordinate");
    vec[0] = 8'd3; vec[1] = 8'd7; vec[2] = 8'h55; vec[3] = 8'hAA;
    t_xform(1'b0, "R4/R5 element order and truncation");

    // back-to-back transform with stray requests while busy
    vec[0] = 8'h90; vec[1] = 8'h11; vec[2] = 8'h40; vec[3] = 8'h08;
    t_xform(1'b1, "R9 requests while busy ignored");
    loadReq = 0; dumpReq = 0; startReq = 0;
    @(negedge clk);
    t_dump(1'b0, "R9 matrix unchanged by stray load");

    // saturation with the largest coefficient
    for (int k = 0; k < 16; k++) mat[k] = 9'h1FF;
    t_load(1'b0, "R2 busy during load");
    vec[0] = 8'hFF; vec[1] = 8'h00; vec[2] = 8'h00; vec[3] = 8'h01;
    t_xform(1'b0, "R5 saturating sum");
    vec[0] = 8'h01; vec[1] = 8'h01; vec[2] = 8'h01; vec[3] = 8'h01;
    t_xform(1'b0, "R5 small products");

    // simultaneous requests
    for (int k = 0; k < 16; k++) mat[k] = 9'(k * 31 + 1);
    t_load(1'b1, "R10 load wins");
    @(negedge clk);
    t_dump(1'b1, "R10 dump wins over start");
    @(negedge clk);
    chk(busy == 0, "R10 start not taken", int'(busy), 0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule